// File: doc/BRIEF.md
# SPI Receive Status Flag Controller

This block holds the receive-side status of a serial peripheral as seen by a processor: a receive-full flag, an overrun flag and a mode-fault flag, plus the last accepted received byte. A one-cycle receive-complete strobe with its byte takes the place of the shifter. The processor reads a status location and a data location, and writes a control location. The block turns those accesses into strobes that clear the flags in a fixed order.

A flag clears only in two steps. First a status read has to find the flag set. Then a later access of the right kind finishes the job: a data read for receive-full and overrun, a control write for mode-fault. The status read arms only the flags that were set at that moment, so a flag raised after the read stays set through the access that follows. When a byte arrives while receive-full is still pending, it is dropped, the older byte stays visible and overrun is raised. One request line combines the sources. Receive-full has its own enable. Overrun and mode-fault share a single error enable.

Top module: `spi_rx_flags`

## Requirements
- R1: A receive-complete strobe that finds receive-full clear (or being cleared in that cycle) loads its byte into the data output and sets receive-full at the next clock edge.
- R2: Receive-full clears only on a data read that follows a status read which saw it set. A data read with no such preceding status read leaves it set.
- R3: A receive-complete strobe that finds receive-full set, with no clearing data read in that cycle, sets overrun and leaves the data output unchanged.
- R4: Overrun clears on a data read that follows a status read which saw overrun set.
- R5: Mode-fault is set on a high-to-low change of the active-low slave-select input, and only when master mode and the mode-fault enable are both 1.
- R6: Setting the mode-fault enable to 0 does not clear a pending mode-fault, but it prevents a new one from being set.
- R7: irq is 1 exactly when (receive-full and rx_ie) or (err_ie and (overrun or mode-fault)). err_ie enables overrun and mode-fault together.
- R8: A status read arms only the flags set at that moment. A flag set later is not cleared by the data read or control write that follows.
- R9: Mode-fault clears on a control write that follows a status read which saw it set. Data reads do not clear it, and a control write with no such armed status read leaves it set.
- R10: Reset clears all three flags, the data output and any armed clear state.
- R11: If a receive-complete strobe coincides with a data read that clears receive-full, the new byte is accepted, receive-full stays set and overrun is not raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_done | input | 1 | One-cycle receive-complete strobe |
| rx_byte | input | W | Byte delivered with rx_done |
| ss_n | input | 1 | Slave-select level, active low |
| master | input | 1 | 1 when the peripheral runs as master |
| modf_en | input | 1 | Mode-fault detection enable |
| err_ie | input | 1 | Shared enable for overrun and mode-fault requests |
| rx_ie | input | 1 | Enable for the receive-full request |
| stat_rd | input | 1 | Status location read strobe |
| data_rd | input | 1 | Data location read strobe |
| ctrl_wr | input | 1 | Control location write strobe |
| data_out | output | W | Last accepted received byte |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |
| mode_fault | output | 1 | Mode-fault flag |
| irq | output | 1 | Shared receiver/error interrupt request |

## Verification
The properties assume that every strobe lasts one cycle and comes from logic on the same clock. They also assume that slave-select is already synchronous to clk, since the block samples it directly to detect the falling edge. The stimulus changes every input only at the falling clock edge. It never raises a status read and a clearing access in the same cycle. It issues no receive-complete strobe until the internal reset release has finished, so each clocked property sees the exact cycle of the request that caused it.

// File: rtl/spi_rxf_pkg.sv
package spi_rxf_pkg;
  // Flag slots used by the clear-sequence tracker
  localparam int FLAG_FULL = 0;
  localparam int FLAG_OVR  = 1;
  localparam int FLAG_MODF = 2;
  localparam int NFLAG     = 3;

  typedef struct packed {
    logic modf;
    logic ovr;
    logic full;
  } rxf_flags_t;
endpackage

// File: rtl/spi_rxf_rst_sync.sv
module spi_rxf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/spi_rxf_clr_arm.sv
// Per-flag memory of the status-read step of a clear sequence.
module spi_rxf_clr_arm #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [N-1:0] flags,
  input  logic [N-1:0] consume,
  output logic [N-1:0] clr
);
  logic [N-1:0] arm_q;
  logic [N-1:0] arm_d;

  for (genvar i = 0; i < N; i++) begin : g_arm
    always_comb begin
      if (capture)         arm_d[i] = flags[i];
      else if (consume[i]) arm_d[i] = 1'b0;
      else                 arm_d[i] = arm_q[i];
    end
    assign clr[i] = arm_q[i] & consume[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_d;
  end
endmodule

// File: rtl/spi_rxf_hold.sv
// Received-byte holding register with explicit load enable.
module spi_rxf_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] q;
  logic [W-1:0] d;

  always_comb begin
    d = load ? din : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign dout = q;
endmodule

// File: rtl/spi_rx_flags.sv
module spi_rx_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_done,
  input  logic [W-1:0] rx_byte,
  input  logic         ss_n,
  input  logic         master,
  input  logic         modf_en,
  input  logic         err_ie,
  input  logic         rx_ie,
  input  logic         stat_rd,
  input  logic         data_rd,
  input  logic         ctrl_wr,
  output logic [W-1:0] data_out,
  output logic         rx_full,
  output logic         overrun,
  output logic         mode_fault,
  output logic         irq
);
  import spi_rxf_pkg::*;

  logic             rst_sync_n;
  rxf_flags_t       flg_q, flg_d;
  logic             ss_q, ss_d;
  logic [NFLAG-1:0] flag_vec, consume, clr;
  logic             full_keep, accept, ovr_set, modf_set;

  spi_rxf_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  always_comb begin
    flag_vec            = '0;
    flag_vec[FLAG_FULL] = flg_q.full;
    flag_vec[FLAG_OVR]  = flg_q.ovr;
    flag_vec[FLAG_MODF] = flg_q.modf;
    consume             = '0;
    consume[FLAG_FULL]  = data_rd;
    consume[FLAG_OVR]   = data_rd;
    consume[FLAG_MODF]  = ctrl_wr;
  end

  spi_rxf_clr_arm #(.N(NFLAG)) u_arm (
    .clk(clk), .rst_n(rst_sync_n), .capture(stat_rd),
    .flags(flag_vec), .consume(consume), .clr(clr)
  );

  // Next-state of the flags
  always_comb begin
    full_keep  = flg_q.full & ~clr[FLAG_FULL];
    accept     = rx_done & ~full_keep;
    ovr_set    = rx_done & full_keep;
    modf_set   = master & modf_en & ss_q & ~ss_n;
    flg_d.full = full_keep | accept;
    flg_d.ovr  = (flg_q.ovr & ~clr[FLAG_OVR]) | ovr_set;
    flg_d.modf = (flg_q.modf & ~clr[FLAG_MODF]) | modf_set;
    ss_d       = ss_n;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flg_q <= '0;
      ss_q  <= 1'b1;
    end else begin
      flg_q <= flg_d;
      ss_q  <= ss_d;
    end
  end

  spi_rxf_hold #(.W(W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .load(accept),
    .din(rx_byte), .dout(data_out)
  );

  assign rx_full    = flg_q.full;
  assign overrun    = flg_q.ovr;
  assign mode_fault = flg_q.modf;
  assign irq        = (flg_q.full & rx_ie) | (err_ie & (flg_q.ovr | flg_q.modf));
endmodule

// File: rtl/spi_rx_flags_chk.sv
module spi_rx_flags_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         rx_done,
  input logic [W-1:0] rx_byte,
  input logic         ss_n,
  input logic         master,
  input logic         modf_en,
  input logic         err_ie,
  input logic         rx_ie,
  input logic         data_rd,
  input logic         ctrl_wr,
  input logic [W-1:0] data_out,
  input logic         rx_full,
  input logic         overrun,
  input logic         mode_fault,
  input logic         irq
);
  p_load_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (rx_done && !rx_full) |=> (rx_full && data_out == $past(rx_byte)));

  p_hold_full_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (rx_full && !data_rd) |=> rx_full);

  p_overrun_keep_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (rx_done && rx_full && !data_rd) |=> (overrun && $stable(data_out)));

  p_modf_gate_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (!mode_fault && !(modf_en && master)) |=> !mode_fault);

  p_modf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (mode_fault && !ctrl_wr) |=> mode_fault);

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (!err_ie && !rx_ie) |-> !irq);

  p_irq_err_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (err_ie && (overrun || mode_fault)) |-> irq);

  p_modf_no_edge_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (!mode_fault && ss_n) |=> !mode_fault);
endmodule

bind spi_rx_flags spi_rx_flags_chk #(.W(W)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .rx_done(rx_done), .rx_byte(rx_byte),
  .ss_n(ss_n), .master(master), .modf_en(modf_en), .err_ie(err_ie),
  .rx_ie(rx_ie), .data_rd(data_rd), .ctrl_wr(ctrl_wr), .data_out(data_out),
  .rx_full(rx_full), .overrun(overrun), .mode_fault(mode_fault), .irq(irq)
);

// File: tb/spi_rx_flags_test.sv
module spi_rx_flags_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_done, ss_n, master, modf_en, err_ie, rx_ie;
  logic       stat_rd, data_rd, ctrl_wr;
  logic [7:0] rx_byte, data_out;
  logic       rx_full, overrun, mode_fault, irq;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  spi_rx_flags #(.W(8)) uut (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .ss_n(ss_n), .master(master), .modf_en(modf_en), .err_ie(err_ie),
    .rx_ie(rx_ie), .stat_rd(stat_rd), .data_rd(data_rd), .ctrl_wr(ctrl_wr),
    .data_out(data_out), .rx_full(rx_full), .overrun(overrun),
    .mode_fault(mode_fault), .irq(irq)
  );

  typedef struct packed {
    logic [7:0] req;
    logic       rx;  logic [7:0] byt;
    logic       ss;  logic mst; logic mfen; logic eie; logic rie;
    logic       srd; logic drd; logic cwr;
    logic       e_full; logic e_ovr; logic e_modf; logic e_irq;
    logic [7:0] e_dat;
  } vec_t;

  localparam int NV = 34;
  //        req rx byte  ss mst mfe eie rie srd drd cwr | full ovr modf irq data
  localparam vec_t TBL [NV] = '{
    '{8'd1,  1,8'hA5, 1,0,0,0,1, 0,0,0, 1,0,0,1,8'hA5}, // R1 load
    '{8'd2,  0,8'h00, 1,0,0,0,1, 1,0,0, 1,0,0,1,8'hA5}, // R2 status read
    '{8'd2,  0,8'h00, 1,0,0,0,1, 0,1,0, 0,0,0,0,8'hA5}, // R2 data read clears
    '{8'd1,  1,8'h3C, 1,0,0,0,1, 0,0,0, 1,0,0,1,8'h3C}, // R1
    '{8'd2,  0,8'h00, 1,0,0,0,1, 0,1,0, 1,0,0,1,8'h3C}, // R2 unarmed read
    '{8'd3,  1,8'h77, 1,0,0,0,1, 0,0,0, 1,1,0,1,8'h3C}, // R3 overrun, keep old
    '{8'd4,  0,8'h00, 1,0,0,1,1, 1,0,0, 1,1,0,1,8'h3C}, // R4 status read
    '{8'd4,  0,8'h00, 1,0,0,1,1, 0,1,0, 0,0,0,0,8'h3C}, // R4 both clear
    '{8'd7,  1,8'h11, 1,0,0,1,0, 0,0,0, 1,0,0,0,8'h11}, // R7 full masked
    '{8'd8,  0,8'h00, 1,0,0,1,0, 1,0,0, 1,0,0,0,8'h11}, // R8 arm full only
    '{8'd8,  1,8'h22, 1,0,0,1,0, 0,0,0, 1,1,0,1,8'h11}, // R8 overrun after read
    '{8'd8,  0,8'h00, 1,0,0,1,0, 0,1,0, 0,1,0,1,8'h11}, // R8 overrun survives
    '{8'd4,  0,8'h00, 1,0,0,1,0, 1,0,0, 0,1,0,1,8'h11}, // R4
    '{8'd4,  0,8'h00, 1,0,0,1,0, 0,1,0, 0,0,0,0,8'h11}, // R4
    '{8'd5,  0,8'h00, 1,1,1,1,0, 0,0,0, 0,0,0,0,8'h11}, // R5 no edge yet
    '{8'd5,  0,8'h00, 0,1,1,1,0, 0,0,0, 0,0,1,1,8'h11}, // R5 falling edge
    '{8'd6,  0,8'h00, 0,1,0,1,0, 0,0,0, 0,0,1,1,8'h11}, // R6 enable off keeps
    '{8'd9,  0,8'h00, 0,1,0,1,0, 1,0,0, 0,0,1,1,8'h11}, // R9 status read
    '{8'd9,  0,8'h00, 0,1,0,1,0, 0,1,0, 0,0,1,1,8'h11}, // R9 data read no clear
    '{8'd9,  0,8'h00, 0,1,0,1,0, 0,0,1, 0,0,0,0,8'h11}, // R9 control write clears
    '{8'd6,  0,8'h00, 1,1,0,1,0, 0,0,0, 0,0,0,0,8'h11}, // R6
    '{8'd6,  0,8'h00, 0,1,0,1,0, 0,0,0, 0,0,0,0,8'h11}, // R6 disabled edge
    '{8'd5,  0,8'h00, 1,0,1,1,0, 0,0,0, 0,0,0,0,8'h11}, // R5
    '{8'd5,  0,8'h00, 0,0,1,1,0, 0,0,0, 0,0,0,0,8'h11}, // R5 slave edge ignored
    '{8'd5,  0,8'h00, 1,1,1,1,0, 0,0,0, 0,0,0,0,8'h11}, // R5
    '{8'd5,  0,8'h00, 0,1,1,1,0, 0,0,0, 0,0,1,1,8'h11}, // R5 edge again
    '{8'd9,  0,8'h00, 0,1,1,1,0, 0,0,1, 0,0,1,1,8'h11}, // R9 unarmed write
    '{8'd7,  0,8'h00, 0,1,1,0,0, 0,0,0, 0,0,1,0,8'h11}, // R7 err masked
    '{8'd9,  0,8'h00, 0,1,1,0,0, 1,0,0, 0,0,1,0,8'h11}, // R9
    '{8'd9,  0,8'h00, 0,1,1,0,0, 0,0,1, 0,0,0,0,8'h11}, // R9
    '{8'd1,  1,8'h5A, 0,1,1,0,1, 0,0,0, 1,0,0,1,8'h5A}, // R1
    '{8'd11, 0,8'h00, 0,1,1,0,1, 1,0,0, 1,0,0,1,8'h5A}, // R11 status read
    '{8'd11, 1,8'h6B, 0,1,1,0,1, 0,1,0, 1,0,0,1,8'h6B}, // R11 same-cycle accept
    '{8'd2,  0,8'h00, 0,1,1,0,1, 0,1,0, 1,0,0,1,8'h6B}  // R2 arm consumed
  };

  task automatic idle();
    rx_done = 0; rx_byte = 8'h00; stat_rd = 0; data_rd = 0; ctrl_wr = 0;
  endtask

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp,
                       input logic [7:0] gd, input logic [7:0] ed);
    checks++;
    if (got !== exp || gd !== ed) begin
      errors++;
      $display("FAIL %s flags(full,ovr,modf,irq)=%b exp %b data=%h exp %h",
               tag, got, exp, gd, ed);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    idle(); ss_n = 1; master = 0; modf_en = 0; err_ie = 0; rx_ie = 0;
    @(negedge clk);
    do_reset();
    check("R10 reset state", {rx_full, overrun, mode_fault, irq}, 4'b0000, data_out, 8'h00);

    for (int i = 0; i < NV; i++) begin
      rx_done = TBL[i].rx;  rx_byte = TBL[i].byt; ss_n = TBL[i].ss;
      master = TBL[i].mst; modf_en = TBL[i].mfen; err_ie = TBL[i].eie;
      rx_ie = TBL[i].rie;  stat_rd = TBL[i].srd; data_rd = TBL[i].drd;
      ctrl_wr = TBL[i].cwr;
      @(negedge clk);
      check($sformatf("vector %0d R%0d", i, TBL[i].req),
            {rx_full, overrun, mode_fault, irq},
            {TBL[i].e_full, TBL[i].e_ovr, TBL[i].e_modf, TBL[i].e_irq},
            data_out, TBL[i].e_dat);
    end
    idle();

    // R10: reset mid-run drops flags, data and a pending arm
    ss_n = 1; master = 0; modf_en = 0; err_ie = 1; rx_ie = 1;
    stat_rd = 1; @(negedge clk); stat_rd = 0;
    do_reset();
    check("R10 mid-run reset", {rx_full, overrun, mode_fault, irq}, 4'b0000, data_out, 8'h00);
    rx_done = 1; rx_byte = 8'h99; @(negedge clk); rx_done = 0;
    check("R1 after reset", {rx_full, overrun, mode_fault, irq}, 4'b1001, data_out, 8'h99);
    data_rd = 1; @(negedge clk); data_rd = 0;
    check("R10 arm cleared by reset", {rx_full, overrun, mode_fault, irq}, 4'b1001, data_out, 8'h99);

    // R3: second overrun while overrun already set keeps oldest byte
    rx_done = 1; rx_byte = 8'hC1; @(negedge clk);
    rx_byte = 8'hC2; @(negedge clk); rx_done = 0;
    check("R3 repeated overrun", {rx_full, overrun, mode_fault, irq}, 4'b1101, data_out, 8'h99);
    stat_rd = 1; @(negedge clk); stat_rd = 0;
    data_rd = 1; @(negedge clk); data_rd = 0;
    check("R4 clear after double overrun", {rx_full, overrun, mode_fault, irq}, 4'b0000, data_out, 8'h99);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R10 run did not end: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule